// File: doc/BRIEF.md
# Sync Event Router with Clock-Domain Crossing

This block takes two periodic synchronisation pulses from a fieldbus slave controller that runs on its own 100 MHz clock. It distributes each pulse to five consumers spread over two host clock domains. Core A has an interrupt, a coprocessor interrupt and a DMA trigger. Core B has an interrupt and a DMA trigger. Every rising sync edge becomes a toggle in the source domain. Each destination domain synchronises that toggle through two flops and turns it back into one event.

A small register port in the core A clock domain holds the routing state. Each source has its own enable word, with one bit per destination. A shared mask word and a shared write-one-to-clear word act on the two interrupt destinations only. A mode word selects pulse or level signalling for the core B interrupt. A read-only cause word shows which interrupt events were captured. Enable decides whether an event is captured at all. Mask decides only whether a captured event reaches an interrupt pin. The coprocessor interrupt and the DMA triggers answer to their enable bits alone.

Top module: `sync_event_router`

## Requirements
- R1: The routing word for source s sits at address s (0 or 1). Its bits select the destinations: bit 0 core A interrupt, bit 1 coprocessor interrupt, bit 2 core A DMA trigger, bit 3 core B interrupt, bit 4 core B DMA trigger. The mask word is at address 2 and the mode word at address 5, each using bit s for source s. The clear word is at address 3 and always reads as zero. Reads are combinational on `regAddr`.
- R2: After reset every register reads zero and every output is low.
- R3: With every destination of a source enabled and its mask bit set, each rising edge of that source gives exactly one single-cycle pulse on each core A output and each core B output of that source. The other source's outputs stay quiet. Sync edges must be at least three destination clocks apart.
- R4: A destination whose enable bit is clear gives no output. Enabled destinations of the same source are unaffected.
- R5: Sync edges that arrive while a destination is disabled are dropped. Enabling the destination later produces no delayed output for them.
- R6: The cause word at address 4 holds one bit per source and core. Bit s is the core A cause of source s and bit 2+s is the core B cause. A bit is set by an event on an enabled interrupt route (bit 0 or bit 3 of the routing word), whatever the mask.
- R7: A mask bit of zero keeps both the core A and the core B interrupt of that source low. It has no effect on the coprocessor interrupt or on either DMA trigger.
- R8: Writing 1 to bit s of the clear word clears both cause bits of source s. A cause bit holds until it is cleared. An event in the same cycle as the clear keeps the bit set.
- R9: With mode bit s set, the core B interrupt of source s stays high while its cause is set and its mask bit is 1, and falls after a clear. With the mode bit clear, it gives one core B clock pulse per event.
- R10: The core B DMA trigger is always a single core B clock pulse per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| syncClk | input | 1 | 100 MHz clock of the sync sources |
| syncRstN | input | 1 | Active-low asynchronous reset, source domain |
| syncIn | input | 2 | Sync pulses; bit 0 is SYNC0, bit 1 is SYNC1 |
| aClk | input | 1 | Core A system clock; also clocks the register port |
| aRstN | input | 1 | Active-low asynchronous reset, core A domain |
| bClk | input | 1 | Core B system clock |
| bRstN | input | 1 | Active-low asynchronous reset, core B domain |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 5 | Register write data |
| regRdData | output | 5 | Register read data |
| aIntOut | output | 2 | Core A interrupt pulse per source |
| aCoprocIntOut | output | 2 | Coprocessor interrupt pulse per source |
| aDmaTrigOut | output | 2 | Core A DMA trigger pulse per source |
| bIntOut | output | 2 | Core B interrupt, pulse or level, per source |
| bDmaTrigOut | output | 2 | Core B DMA trigger pulse per source |

## Verification
The bench counts output pulses in each destination domain and compares the counts with the number of sync edges it drove. A crossing that drops or doubles an edge therefore shows up as a wrong count on one core. It fires edges while a route is disabled and then enables the route. A design that remembered those edges would emit late pulses, and one that captured them would show a set cause bit. It removes the mask with every route enabled. A design that let the mask gate the capture would lose the cause bit, and one that masked the DMA or coprocessor routes would lose their pulses. In level mode it holds the core B interrupt across many cycles and then clears it. A clear that never crosses to core B would leave the line stuck high.

// File: rtl/sync_route_pkg.sv
package sync_route_pkg;
  localparam int NUM_SRC  = 2;
  localparam int NUM_DEST = 5;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = NUM_DEST;
  localparam int CAUSE_W  = 2 * NUM_SRC;

  // destination bit positions inside a routing word
  localparam int D_A_INT = 0;
  localparam int D_A_COP = 1;
  localparam int D_A_DMA = 2;
  localparam int D_B_INT = 3;
  localparam int D_B_DMA = 4;

  // register addresses; routing words occupy 0 .. NUM_SRC-1
  localparam logic [ADDR_W-1:0] ADR_MASK  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CLEAR = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CAUSE = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_MODE  = 3'd5;

  typedef logic [NUM_SRC-1:0][NUM_DEST-1:0] routeCfg_t;

  typedef struct packed {
    logic [NUM_SRC-1:0] clrPulse;
  } ctrlStrb_t;
endpackage

// File: rtl/sync_route_bitsync.sv
module sync_route_bitsync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qOut
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stg <= '0;
    end else begin
      stg[0] <= dIn;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign qOut = stg[STAGES-1];
endmodule

// File: rtl/sync_route_edge_tx.sv
module sync_route_edge_tx (
  input  logic clk,
  input  logic rstN,
  input  logic syncIn,
  output logic tglOut
);
  logic prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ  <= 1'b0;
      tglOut <= 1'b0;
    end else begin
      prevQ <= syncIn;
      if (syncIn && !prevQ) tglOut <= ~tglOut;
    end
  end
endmodule

// File: rtl/sync_route_tgl_rx.sv
module sync_route_tgl_rx #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tglIn,
  output logic pulseOut
);
  logic syncedQ;
  logic lastQ;

  sync_route_bitsync #(.WIDTH(1), .STAGES(STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (tglIn),
    .qOut (syncedQ)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastQ <= 1'b0;
    else       lastQ <= syncedQ;
  end

  assign pulseOut = syncedQ ^ lastQ;
endmodule

// File: rtl/sync_route_ctrl.sv
module sync_route_ctrl
  import sync_route_pkg::*;
(
  input  logic                 aClk,
  input  logic                 aRstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic [CAUSE_W-1:0]   causeIn,
  output routeCfg_t            cfgQ,
  output logic [NUM_SRC-1:0]   maskQ,
  output logic [NUM_SRC-1:0]   modeQ,
  output ctrlStrb_t            strb
);
  always_ff @(posedge aClk or negedge aRstN) begin
    if (!aRstN) begin
      cfgQ  <= '0;
      maskQ <= '0;
      modeQ <= '0;
    end else if (regWrEn) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (regAddr == ADDR_W'(s)) cfgQ[s] <= regWrData;
      end
      if (regAddr == ADR_MASK) maskQ <= regWrData[NUM_SRC-1:0];
      if (regAddr == ADR_MODE) modeQ <= regWrData[NUM_SRC-1:0];
    end
  end

  always_comb begin
    strb = '0;
    if (regWrEn && regAddr == ADR_CLEAR) strb.clrPulse = regWrData[NUM_SRC-1:0];
  end

  always_comb begin
    regRdData = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (regAddr == ADDR_W'(s)) regRdData = cfgQ[s];
    end
    case (regAddr)
      ADR_MASK:  regRdData = DATA_W'(maskQ);
      ADR_MODE:  regRdData = DATA_W'(modeQ);
      ADR_CAUSE: regRdData = DATA_W'(causeIn);
      default:   ;
    endcase
  end
endmodule

// File: rtl/sync_route_dp.sv
module sync_route_dp
  import sync_route_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                syncClk,
  input  logic                syncRstN,
  input  logic [NUM_SRC-1:0]  syncIn,
  input  logic                aClk,
  input  logic                aRstN,
  input  logic                bClk,
  input  logic                bRstN,
  input  routeCfg_t           cfgQ,
  input  logic [NUM_SRC-1:0]  maskQ,
  input  logic [NUM_SRC-1:0]  modeQ,
  input  ctrlStrb_t           strb,
  output logic [CAUSE_W-1:0]  causeOut,
  output logic [NUM_SRC-1:0]  aIntOut,
  output logic [NUM_SRC-1:0]  aCoprocIntOut,
  output logic [NUM_SRC-1:0]  aDmaTrigOut,
  output logic [NUM_SRC-1:0]  bIntOut,
  output logic [NUM_SRC-1:0]  bDmaTrigOut
);
  localparam int BX_W = 4 * NUM_SRC;

  logic [NUM_SRC-1:0] srcTgl, evA, evB, clrTglA, clrB;
  logic [NUM_SRC-1:0] causeA, causeB, causeBinA;
  logic [BX_W-1:0]    bxIn, bxSync;
  logic [NUM_SRC-1:0] enBInt, enBDma, maskB, modeB;

  // per-source edge capture and crossing into both host domains
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    sync_route_edge_tx u_tx (
      .clk    (syncClk),
      .rstN   (syncRstN),
      .syncIn (syncIn[s]),
      .tglOut (srcTgl[s])
    );
    sync_route_tgl_rx #(.STAGES(SYNC_STAGES)) u_rxA (
      .clk      (aClk),
      .rstN     (aRstN),
      .tglIn    (srcTgl[s]),
      .pulseOut (evA[s])
    );
    sync_route_tgl_rx #(.STAGES(SYNC_STAGES)) u_rxB (
      .clk      (bClk),
      .rstN     (bRstN),
      .tglIn    (srcTgl[s]),
      .pulseOut (evB[s])
    );
    sync_route_tgl_rx #(.STAGES(SYNC_STAGES)) u_clrB (
      .clk      (bClk),
      .rstN     (bRstN),
      .tglIn    (clrTglA[s]),
      .pulseOut (clrB[s])
    );
    assign bxIn[4*s +: 4] = {modeQ[s], maskQ[s], cfgQ[s][D_B_DMA], cfgQ[s][D_B_INT]};
    assign enBInt[s] = bxSync[4*s];
    assign enBDma[s] = bxSync[4*s+1];
    assign maskB[s]  = bxSync[4*s+2];
    assign modeB[s]  = bxSync[4*s+3];
  end

  // quasi-static settings into core B
  sync_route_bitsync #(.WIDTH(BX_W), .STAGES(SYNC_STAGES)) u_bxSync (
    .clk  (bClk),
    .rstN (bRstN),
    .dIn  (bxIn),
    .qOut (bxSync)
  );

  // core B cause bits back into core A for reading
  sync_route_bitsync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_causeBack (
    .clk  (aClk),
    .rstN (aRstN),
    .dIn  (causeB),
    .qOut (causeBinA)
  );

  // core A side: capture, gating, clear toggles
  always_ff @(posedge aClk or negedge aRstN) begin
    if (!aRstN) begin
      causeA        <= '0;
      clrTglA       <= '0;
      aIntOut       <= '0;
      aCoprocIntOut <= '0;
      aDmaTrigOut   <= '0;
    end else begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (evA[s] && cfgQ[s][D_A_INT])  causeA[s] <= 1'b1;
        else if (strb.clrPulse[s])       causeA[s] <= 1'b0;
        if (strb.clrPulse[s])            clrTglA[s] <= ~clrTglA[s];
        aIntOut[s]       <= evA[s] && cfgQ[s][D_A_INT] && maskQ[s];
        aCoprocIntOut[s] <= evA[s] && cfgQ[s][D_A_COP];
        aDmaTrigOut[s]   <= evA[s] && cfgQ[s][D_A_DMA];
      end
    end
  end

  // core B side: capture, pulse or level interrupt, DMA pulse
  always_ff @(posedge bClk or negedge bRstN) begin
    if (!bRstN) begin
      causeB      <= '0;
      bIntOut     <= '0;
      bDmaTrigOut <= '0;
    end else begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (evB[s] && enBInt[s]) causeB[s] <= 1'b1;
        else if (clrB[s])        causeB[s] <= 1'b0;
        if (modeB[s]) bIntOut[s] <= causeB[s] && maskB[s];
        else          bIntOut[s] <= evB[s] && enBInt[s] && maskB[s];
        bDmaTrigOut[s] <= evB[s] && enBDma[s];
      end
    end
  end

  assign causeOut = {causeBinA, causeA};
endmodule

// File: rtl/sync_event_router.sv
module sync_event_router
  import sync_route_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                syncClk,
  input  logic                syncRstN,
  input  logic [NUM_SRC-1:0]  syncIn,
  input  logic                aClk,
  input  logic                aRstN,
  input  logic                bClk,
  input  logic                bRstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic [NUM_SRC-1:0]  aIntOut,
  output logic [NUM_SRC-1:0]  aCoprocIntOut,
  output logic [NUM_SRC-1:0]  aDmaTrigOut,
  output logic [NUM_SRC-1:0]  bIntOut,
  output logic [NUM_SRC-1:0]  bDmaTrigOut
);
  routeCfg_t          cfgQ;
  logic [NUM_SRC-1:0] maskQ, modeQ;
  logic [CAUSE_W-1:0] causeAll;
  ctrlStrb_t          ctrlStrb;

  sync_route_ctrl u_ctrl (
    .aClk      (aClk),
    .aRstN     (aRstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .causeIn   (causeAll),
    .cfgQ      (cfgQ),
    .maskQ     (maskQ),
    .modeQ     (modeQ),
    .strb      (ctrlStrb)
  );

  sync_route_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .syncClk       (syncClk),
    .syncRstN      (syncRstN),
    .syncIn        (syncIn),
    .aClk          (aClk),
    .aRstN         (aRstN),
    .bClk          (bClk),
    .bRstN         (bRstN),
    .cfgQ          (cfgQ),
    .maskQ         (maskQ),
    .modeQ         (modeQ),
    .strb          (ctrlStrb),
    .causeOut      (causeAll),
    .aIntOut       (aIntOut),
    .aCoprocIntOut (aCoprocIntOut),
    .aDmaTrigOut   (aDmaTrigOut),
    .bIntOut       (bIntOut),
    .bDmaTrigOut   (bDmaTrigOut)
  );
endmodule

// File: rtl/sync_event_router_chk.sv
module sync_event_router_chk
  import sync_route_pkg::*;
(
  input logic                aClk,
  input logic                aRstN,
  input logic                bClk,
  input logic                bRstN,
  input routeCfg_t           cfgVec,
  input logic [NUM_SRC-1:0]  maskVec,
  input logic [NUM_SRC-1:0]  clrVec,
  input logic [CAUSE_W-1:0]  causeVec,
  input logic [NUM_SRC-1:0]  aIntOut,
  input logic [NUM_SRC-1:0]  aCoprocIntOut,
  input logic [NUM_SRC-1:0]  aDmaTrigOut,
  input logic [NUM_SRC-1:0]  bDmaTrigOut
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
    // R3: core A outputs are one cycle wide
    assert_a_int_pulse_R3: assert property (@(posedge aClk) disable iff (!aRstN)
      aIntOut[s] |=> !aIntOut[s]);
    assert_a_cop_pulse_R3: assert property (@(posedge aClk) disable iff (!aRstN)
      aCoprocIntOut[s] |=> !aCoprocIntOut[s]);
    assert_a_dma_pulse_R3: assert property (@(posedge aClk) disable iff (!aRstN)
      aDmaTrigOut[s] |=> !aDmaTrigOut[s]);

    // R4: a disabled core A route stays silent
    assert_a_int_enable_R4: assert property (@(posedge aClk) disable iff (!aRstN)
      !$past(cfgVec[s][D_A_INT]) |-> !aIntOut[s]);
    assert_a_cop_enable_R4: assert property (@(posedge aClk) disable iff (!aRstN)
      !$past(cfgVec[s][D_A_COP]) |-> !aCoprocIntOut[s]);
    assert_a_dma_enable_R4: assert property (@(posedge aClk) disable iff (!aRstN)
      !$past(cfgVec[s][D_A_DMA]) |-> !aDmaTrigOut[s]);

    // R7: no core A interrupt without the mask bit
    assert_mask_gate_R7: assert property (@(posedge aClk) disable iff (!aRstN)
      aIntOut[s] |-> $past(maskVec[s]));

    // R8: a core A cause holds until cleared
    assert_cause_hold_R8: assert property (@(posedge aClk) disable iff (!aRstN)
      (causeVec[s] && !clrVec[s]) |=> causeVec[s]);

    // R10: core B DMA trigger is one cycle wide
    assert_b_dma_pulse_R10: assert property (@(posedge bClk) disable iff (!bRstN)
      bDmaTrigOut[s] |=> !bDmaTrigOut[s]);
  end
endmodule

bind sync_event_router sync_event_router_chk i_chk (
  .aClk          (aClk),
  .aRstN         (aRstN),
  .bClk          (bClk),
  .bRstN         (bRstN),
  .cfgVec        (cfgQ),
  .maskVec       (maskQ),
  .clrVec        (ctrlStrb.clrPulse),
  .causeVec      (causeAll),
  .aIntOut       (aIntOut),
  .aCoprocIntOut (aCoprocIntOut),
  .aDmaTrigOut   (aDmaTrigOut),
  .bDmaTrigOut   (bDmaTrigOut)
);

// File: tb/test_sync_event_router.sv
module test_sync_event_router;
  logic       syncClk = 1'b0, aClk = 1'b0, bClk = 1'b0;
  logic       syncRstN = 1'b0, aRstN = 1'b0, bRstN = 1'b0;
  logic [1:0] syncIn = '0;
  logic       regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [4:0] regWrData = '0;
  logic [4:0] regRdData;
  logic [1:0] aIntOut, aCoprocIntOut, aDmaTrigOut, bIntOut, bDmaTrigOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  int cAInt[2], cACop[2], cADma[2], cBInt[2], cBDma[2];
  int bAInt[2], bACop[2], bADma[2], bBInt[2], bBDma[2];

  always #4 aClk = ~aClk;     // 125 MHz
  always #5 syncClk = ~syncClk;
  always #7 bClk = ~bClk;

  sync_event_router i_sync_event_router (
    .syncClk(syncClk), .syncRstN(syncRstN), .syncIn(syncIn),
    .aClk(aClk), .aRstN(aRstN), .bClk(bClk), .bRstN(bRstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .aIntOut(aIntOut), .aCoprocIntOut(aCoprocIntOut),
    .aDmaTrigOut(aDmaTrigOut), .bIntOut(bIntOut), .bDmaTrigOut(bDmaTrigOut)
  );

  initial begin
    for (int s = 0; s < 2; s++) begin
      cAInt[s] = 0; cACop[s] = 0; cADma[s] = 0; cBInt[s] = 0; cBDma[s] = 0;
    end
  end

  always @(negedge aClk) begin
    if (aRstN) begin
      for (int s = 0; s < 2; s++) begin
        if (aIntOut[s])       cAInt[s]++;
        if (aCoprocIntOut[s]) cACop[s]++;
        if (aDmaTrigOut[s])   cADma[s]++;
      end
    end
  end

  always @(negedge bClk) begin
    if (bRstN) begin
      for (int s = 0; s < 2; s++) begin
        if (bIntOut[s])     cBInt[s]++;
        if (bDmaTrigOut[s]) cBDma[s]++;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic regWrite(logic [2:0] adr, logic [4:0] dat);
    @(negedge aClk);
    regWrEn = 1'b1; regAddr = adr; regWrData = dat;
    @(negedge aClk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic regRead(logic [2:0] adr, output int dat);
    @(negedge aClk);
    regAddr = adr;
    #1;
    dat = int'(regRdData);
  endtask

  task automatic settle();
    repeat (40) @(negedge aClk);
  endtask

  task automatic snap();
    for (int s = 0; s < 2; s++) begin
      bAInt[s] = cAInt[s]; bACop[s] = cACop[s]; bADma[s] = cADma[s];
      bBInt[s] = cBInt[s]; bBDma[s] = cBDma[s];
    end
  endtask

  task automatic fire(int src, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge syncClk); syncIn[src] = 1'b1;
      repeat (4) @(negedge syncClk); syncIn[src] = 1'b0;
      repeat (16) @(negedge syncClk);
    end
    settle();
  endtask

  task automatic expectDeltas(string req, int s, int ai, int ac, int ad, int bi, int bd);
    chk(req, $sformatf("src%0d coreA int pulses", s), cAInt[s] - bAInt[s], ai);
    chk(req, $sformatf("src%0d coproc pulses", s),    cACop[s] - bACop[s], ac);
    chk(req, $sformatf("src%0d coreA dma pulses", s), cADma[s] - bADma[s], ad);
    chk(req, $sformatf("src%0d coreB int pulses", s), cBInt[s] - bBInt[s], bi);
    chk(req, $sformatf("src%0d coreB dma pulses", s), cBDma[s] - bBDma[s], bd);
  endtask

  task automatic testReset();
    int v;
    for (int a = 0; a < 6; a++) begin
      regRead(3'(a), v);
      chk("R2", $sformatf("reset read addr %0d", a), v, 0);
    end
    chk("R2", "reset outputs", int'({aIntOut, aCoprocIntOut, aDmaTrigOut, bIntOut, bDmaTrigOut}), 0);
  endtask

  task automatic testRegs();
    int v;
    regWrite(3'd0, 5'h1F); regRead(3'd0, v); chk("R1", "route word 0", v, 31);
    regWrite(3'd1, 5'h0A); regRead(3'd1, v); chk("R1", "route word 1", v, 10);
    regWrite(3'd2, 5'h1F); regRead(3'd2, v); chk("R1", "mask width", v, 3);
    regWrite(3'd5, 5'h1E); regRead(3'd5, v); chk("R1", "mode width", v, 2);
    regRead(3'd3, v); chk("R1", "clear reads zero", v, 0);
    regWrite(3'd0, 5'h00); regWrite(3'd1, 5'h00);
    regWrite(3'd2, 5'h00); regWrite(3'd5, 5'h00);
    settle();
  endtask

  task automatic testFanout();
    int v;
    regWrite(3'd0, 5'h1F); regWrite(3'd2, 5'h03); settle();
    snap(); fire(0, 3);
    expectDeltas("R3", 0, 3, 3, 3, 3, 3);
    expectDeltas("R3", 1, 0, 0, 0, 0, 0);
    regRead(3'd4, v); chk("R6", "cause after src0 events", v, 5);
    regWrite(3'd3, 5'h03); settle();
    regRead(3'd4, v); chk("R8", "cause after clear", v, 0);
  endtask

  task automatic testDropNoReplay();
    int v;
    regWrite(3'd1, 5'h00); settle();
    snap(); fire(1, 2);
    expectDeltas("R5", 1, 0, 0, 0, 0, 0);
    regRead(3'd4, v); chk("R5", "no cause while disabled", v, 0);
    regWrite(3'd1, 5'h1F); settle();
    expectDeltas("R5", 1, 0, 0, 0, 0, 0);
    regRead(3'd4, v); chk("R5", "no cause after enable", v, 0);
    fire(1, 1);
    expectDeltas("R3", 1, 1, 1, 1, 1, 1);
    regRead(3'd4, v); chk("R6", "cause after src1 event", v, 10);
    regWrite(3'd3, 5'h02); regWrite(3'd1, 5'h00); settle();
    regRead(3'd4, v); chk("R8", "src1 cause cleared", v, 0);
  endtask

  task automatic testMask();
    int v;
    regWrite(3'd2, 5'h00); regWrite(3'd0, 5'h1F); settle();
    snap(); fire(0, 2);
    expectDeltas("R7", 0, 0, 2, 2, 0, 2);
    regRead(3'd4, v); chk("R6", "cause captured while masked", v, 5);
    regWrite(3'd3, 5'h01); settle();
    regRead(3'd4, v); chk("R8", "masked cause cleared", v, 0);
  endtask

  task automatic testSelective();
    int v;
    regWrite(3'd2, 5'h03); regWrite(3'd0, 5'h02); settle();
    snap(); fire(0, 2);
    expectDeltas("R4", 0, 0, 2, 0, 0, 0);
    regRead(3'd4, v); chk("R4", "no cause on coproc-only route", v, 0);
    regWrite(3'd0, 5'h14); settle();
    snap(); fire(0, 1);
    expectDeltas("R10", 0, 0, 0, 1, 0, 1);
  endtask

  task automatic testLevel();
    int v;
    regWrite(3'd0, 5'h08); regWrite(3'd5, 5'h01); regWrite(3'd2, 5'h03); settle();
    snap(); fire(0, 1);
    chk("R9", "level raised", int'(bIntOut[0]), 1);
    chk("R9", "no coreA int", cAInt[0] - bAInt[0], 0);
    repeat (60) @(negedge aClk);
    chk("R9", "level held", int'(bIntOut[0]), 1);
    regRead(3'd4, v); chk("R6", "coreB cause only", v, 4);
    regWrite(3'd3, 5'h01); settle();
    chk("R9", "level dropped after clear", int'(bIntOut[0]), 0);
    regRead(3'd4, v); chk("R8", "coreB cause cleared", v, 0);
    regWrite(3'd5, 5'h00); settle();
    snap(); fire(0, 2);
    expectDeltas("R9", 0, 0, 0, 0, 2, 0);
    regWrite(3'd3, 5'h01); regWrite(3'd0, 5'h00); settle();
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (10) @(negedge aClk);
    syncRstN = 1'b1; aRstN = 1'b1; bRstN = 1'b1;
    repeat (5) @(negedge aClk);
    testReset();
    testRegs();
    testFanout();
    testDropNoReplay();
    testMask();
    testSelective();
    testLevel();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule